// File: doc/BRIEF.md
# Dual-Channel Codec Port FIFO and Status Interface

This block is the host-side register interface of a serial codec port. The port has two sample channels, audio and telecom, and one codec-control path. Each sample channel has its own data address. A host write to that address pushes a transmit FIFO. A host read from the same address pops a separate receive FIFO. There are four independent 8-deep by 16-bit FIFOs, so both channels run full duplex.

The serial frame engine is outside this block. It is represented by one slot strobe per channel. On each strobe the block moves the head of the transmit FIFO to the channel's outgoing sample and pushes the incoming sample into the receive FIFO. A 21-bit codec-control word written by the host goes out on the next control frame, and the word from the following incoming control frame is held for the host to read.

A status register gathers three kinds of bits:
- sticky error bits, which can interrupt;
- FIFO service requests, which can interrupt;
- level indications, which never interrupt.

These drive one interrupt line.

Top module: `codec_port_regs`

Register map (3-bit address):
- 0: control A. Bit0 is the port enable. Bits 1..4 are the service-request unmask bits for audio-tx, audio-rx, telecom-tx and telecom-rx.
- 1: control B. Bit0 is audio codec on. Bit1 is telecom codec on.
- 2: audio data.
- 3: telecom data.
- 4: codec-control word.
- 5: status.
- 6, 7: unused, read as 0.

Status bits:

| Bit | Meaning |
|-----|---------|
| 0 | audio underrun |
| 1 | audio overrun |
| 2 | telecom underrun |
| 3 | telecom overrun |
| 4 | audio tx service request |
| 5 | audio rx service request |
| 6 | telecom tx service request |
| 7 | telecom rx service request |
| 8 | audio tx not full |
| 9 | audio rx not empty |
| 10 | telecom tx not full |
| 11 | telecom rx not empty |
| 12 | control access done |
| 13 | audio codec on |
| 14 | telecom codec on |

## Requirements
- R1: After reset, the control registers read 0, both outgoing samples are 0, the interrupt is low, and status reads 0x0550. Control A and control B read back the bits that were written to them.
- R2: On a slot strobe while the port is enabled, a channel with a non-empty transmit FIFO presents its oldest entry on its outgoing sample in the cycle after the strobe. Entries leave in write order, and each channel is independent of the other.
- R3: A read of a channel data address returns the oldest receive entry combinationally and removes it. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: A host write to a full transmit FIFO is dropped, and the FIFO never holds more than 8 entries.
- R5: A slot strobe while the receive FIFO holds 8 entries drops the incoming sample and sets that channel's overrun bit.
- R6: A slot strobe while the transmit FIFO is empty sets that channel's underrun bit, and the outgoing sample keeps its previous value.
- R7: Error bits stay set until the host writes 1 to them at the status address. Writing 0 leaves a bit unchanged. A new error event in the same cycle as a clear wins.
- R8: A transmit service request is high while the transmit FIFO holds 4 or fewer entries. A receive service request is high while the receive FIFO holds 4 or more entries.
- R9: The level bits show the not-full, not-empty, control-done and codec-on states. These bits never cause an interrupt.
- R10: A write to the control-word address clears control-done. The word goes out on `cc_tx_word`, with a one-cycle `cc_tx_valid` pulse, after the next enabled `cc_tx_frame`. The next enabled `cc_rx_frame` after that captures `cc_rx_word`, sets control-done, and makes the word readable at address 4.
- R11: The interrupt is high exactly when the port is enabled and either some error bit is set or some service request is set with its unmask bit set.
- R12: While the port enable is 0, slot and frame strobes change no FIFO, sample, error bit or control-word state. Host pushes and pops still act.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops at data addresses) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data |
| aud_slot | input | 1 | Audio frame slot strobe |
| aud_rx_sample | input | 16 | Incoming audio sample |
| aud_tx_sample | output | 16 | Outgoing audio sample |
| tel_slot | input | 1 | Telecom frame slot strobe |
| tel_rx_sample | input | 16 | Incoming telecom sample |
| tel_tx_sample | output | 16 | Outgoing telecom sample |
| cc_tx_frame | input | 1 | Outgoing control-frame strobe |
| cc_tx_word | output | 21 | Control word being sent |
| cc_tx_valid | output | 1 | One-cycle pulse when a control word is sent |
| cc_rx_frame | input | 1 | Incoming control-frame strobe |
| cc_rx_word | input | 21 | Incoming control word |
| irq | output | 1 | Interrupt request |

The FIFOs apply no back-pressure. The host is never stalled. A write to a full transmit FIFO is lost. A slot into a full receive FIFO or from an empty transmit FIFO is flagged as an error and not stalled.

## Verification
Directed sequences push a FIFO past full and drain it past empty, so that dropped writes, overrun, underrun with a held sample, and write-1-to-clear are each told apart from ordinary traffic. FIFO levels are stepped across the half mark to separate the tx and rx threshold directions. Slots with the port disabled show that strobes leave every piece of state alone. A long seeded random mix then interleaves host pushes, pops, clears and control writes with independent strobes on both channels. This exposes ordering, channel crosstalk and same-cycle push/pop or set/clear conflicts that the directed cases do not reach.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam logic [2:0] A_CTRLA = 3'd0;
  localparam logic [2:0] A_CTRLB = 3'd1;
  localparam logic [2:0] A_AUD   = 3'd2;
  localparam logic [2:0] A_TEL   = 3'd3;
  localparam logic [2:0] A_CC    = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
  localparam int NCH      = 2;
  localparam int S_ERR    = 0;   // 2 per channel: underrun, overrun
  localparam int S_SVC    = 4;   // 2 per channel: tx req, rx req
  localparam int S_LVL    = 8;   // 2 per channel: tx not full, rx not empty
  localparam int S_CCDONE = 12;
  localparam int S_ON     = 13;
endpackage

// File: rtl/cp_fifo.sv
module cp_fifo #(
  parameter int W  = 16,
  parameter int D  = 8,
  parameter int CW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(D - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (count != CW'(D));
  assign do_pop  = pop && (count != '0);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) if (do_push) mem[wp] <= wdata;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(D)) && push && !pop |=> count == CW'(D)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(D)); // R4
endmodule

// File: rtl/cp_chan.sv
module cp_chan #(
  parameter int W = 16,
  parameter int D = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         host_push,
  input  logic [W-1:0] host_wdata,
  input  logic         host_pop,
  output logic [W-1:0] host_rdata,
  input  logic         slot,
  input  logic [W-1:0] rx_sample,
  output logic [W-1:0] tx_sample,
  input  logic         clr_unf,
  input  logic         clr_ovr,
  output logic         unf,
  output logic         ovr,
  output logic         tx_req,
  output logic         rx_req,
  output logic         tx_nf,
  output logic         rx_ne
);
  localparam int CW = $clog2(D + 1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [W-1:0]  tx_head, rx_head;
  logic          act, tx_empty, rx_full;

  assign act      = slot && en;
  assign tx_empty = (tx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(D));

  cp_fifo #(.W(W), .D(D), .CW(CW)) u_tx (
    .clk, .rst_n, .push(host_push), .wdata(host_wdata),
    .pop(act && !tx_empty), .rdata(tx_head), .count(tx_cnt));

  cp_fifo #(.W(W), .D(D), .CW(CW)) u_rx (
    .clk, .rst_n, .push(act && !rx_full), .wdata(rx_sample),
    .pop(host_pop), .rdata(rx_head), .count(rx_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sample <= '0;
      unf <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (act && !tx_empty) tx_sample <= tx_head;
      if (act && tx_empty) unf <= 1'b1;
      else if (clr_unf)    unf <= 1'b0;
      if (act && rx_full)  ovr <= 1'b1;
      else if (clr_ovr)    ovr <= 1'b0;
    end
  end

  assign host_rdata = rx_ne ? rx_head : '0;
  assign tx_req = tx_cnt <= CW'(D / 2);
  assign rx_req = rx_cnt >= CW'(D / 2);
  assign tx_nf  = !(tx_cnt == CW'(D));
  assign rx_ne  = rx_cnt != '0;

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    act && tx_empty |=> unf && $stable(tx_sample)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !clr_ovr |=> ovr); // R7
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    act && rx_full && !host_pop |=> rx_cnt == CW'(D) && ovr); // R5
endmodule

// File: rtl/cp_ctl_link.sv
module cp_ctl_link #(
  parameter int CCW = 21
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           host_wr,
  input  logic [CCW-1:0] host_word,
  input  logic           tx_frame,
  input  logic           rx_frame,
  input  logic [CCW-1:0] rx_word,
  output logic [CCW-1:0] tx_word,
  output logic           tx_valid,
  output logic [CCW-1:0] rd_word,
  output logic           done
);
  logic pending, awaiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_valid <= 1'b0;
      rd_word <= '0;
      done <= 1'b0;
      pending <= 1'b0;
      awaiting <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      if (host_wr) begin
        tx_word <= host_word;
        pending <= 1'b1;
        awaiting <= 1'b0;
        done <= 1'b0;
      end else begin
        if (en && tx_frame && pending) begin
          tx_valid <= 1'b1;
          pending <= 1'b0;
          awaiting <= 1'b1;
        end
        if (en && rx_frame && awaiting) begin
          rd_word <= rx_word;
          done <= 1'b1;
          awaiting <= 1'b0;
        end
      end
    end
  end

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> !done && !tx_valid); // R10
  AST_SEND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid || $past(tx_frame)); // R10
endmodule

// File: rtl/codec_port_regs.sv
module codec_port_regs
  import codec_port_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CCW   = 21,
  parameter int BW    = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [BW-1:0]  host_wdata,
  output logic [BW-1:0]  host_rdata,
  input  logic           aud_slot,
  input  logic [DW-1:0]  aud_rx_sample,
  output logic [DW-1:0]  aud_tx_sample,
  input  logic           tel_slot,
  input  logic [DW-1:0]  tel_rx_sample,
  output logic [DW-1:0]  tel_tx_sample,
  input  logic           cc_tx_frame,
  output logic [CCW-1:0] cc_tx_word,
  output logic           cc_tx_valid,
  input  logic           cc_rx_frame,
  input  logic [CCW-1:0] cc_rx_word,
  output logic           irq
);
  localparam int CAW = 1 + 2 * NCH;

  logic [CAW-1:0] ctrl_a;
  logic [NCH-1:0] ctrl_b;
  logic [14:0]    status;
  logic [CCW-1:0] cc_rd;
  logic           cc_done, port_en;
  logic [NCH-1:0] ch_slot, ch_push, ch_pop, c_unf, c_ovr;
  logic [DW-1:0]  ch_rx [NCH];
  logic [DW-1:0]  ch_tx [NCH];
  logic [DW-1:0]  ch_rd [NCH];
  logic           wr_stat;
  logic           unused_bits;

  assign unused_bits = ^host_wdata;
  assign port_en = ctrl_a[0];
  assign wr_stat = host_wr && host_addr == A_STAT;

  assign ch_slot = {tel_slot, aud_slot};
  assign ch_rx[0] = aud_rx_sample;
  assign ch_rx[1] = tel_rx_sample;
  assign aud_tx_sample = ch_tx[0];
  assign tel_tx_sample = ch_tx[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
    end else if (host_wr) begin
      if (host_addr == A_CTRLA) ctrl_a <= host_wdata[CAW-1:0];
      if (host_addr == A_CTRLB) ctrl_b <= host_wdata[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [2:0] MY_ADDR = A_AUD + 3'(c);
    assign ch_push[c] = host_wr && host_addr == MY_ADDR;
    assign ch_pop[c]  = host_rd && host_addr == MY_ADDR;
    cp_chan #(.W(DW), .D(DEPTH)) u_chan (
      .clk, .rst_n, .en(port_en),
      .host_push(ch_push[c]), .host_wdata(host_wdata[DW-1:0]),
      .host_pop(ch_pop[c]), .host_rdata(ch_rd[c]),
      .slot(ch_slot[c]), .rx_sample(ch_rx[c]), .tx_sample(ch_tx[c]),
      .clr_unf(wr_stat && host_wdata[S_ERR + 2*c]),
      .clr_ovr(wr_stat && host_wdata[S_ERR + 2*c + 1]),
      .unf(status[S_ERR + 2*c]), .ovr(status[S_ERR + 2*c + 1]),
      .tx_req(status[S_SVC + 2*c]), .rx_req(status[S_SVC + 2*c + 1]),
      .tx_nf(status[S_LVL + 2*c]), .rx_ne(status[S_LVL + 2*c + 1]));
    assign c_unf[c] = status[S_ERR + 2*c];
    assign c_ovr[c] = status[S_ERR + 2*c + 1];
  end

  cp_ctl_link #(.CCW(CCW)) u_cc (
    .clk, .rst_n, .en(port_en),
    .host_wr(host_wr && host_addr == A_CC), .host_word(host_wdata[CCW-1:0]),
    .tx_frame(cc_tx_frame), .rx_frame(cc_rx_frame), .rx_word(cc_rx_word),
    .tx_word(cc_tx_word), .tx_valid(cc_tx_valid), .rd_word(cc_rd),
    .done(cc_done));

  assign status[S_CCDONE] = cc_done;
  assign status[S_ON +: NCH] = ctrl_b;

  assign irq = port_en && ((|c_unf) || (|c_ovr) ||
               (|(status[S_SVC +: 2*NCH] & ctrl_a[CAW-1:1])));

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRLA: host_rdata = BW'(ctrl_a);
      A_CTRLB: host_rdata = BW'(ctrl_b);
      A_AUD:   host_rdata = BW'(ch_rd[0]);
      A_TEL:   host_rdata = BW'(ch_rd[1]);
      A_CC:    host_rdata = BW'(cc_rd);
      A_STAT:  host_rdata = BW'(status);
      default: host_rdata = '0;
    endcase
  end

  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !irq); // R11
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    port_en && (|status[3:0]) |-> irq); // R11
  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|status[7:0])); // R9
endmodule

// File: tb/tb_codec_port_regs.sv
module tb_codec_port_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic aud_slot = 0, tel_slot = 0, cc_tx_frame = 0, cc_rx_frame = 0;
  logic [15:0] aud_rx_sample = '0, tel_rx_sample = '0;
  logic [15:0] aud_tx_sample, tel_tx_sample;
  logic [20:0] cc_tx_word;
  logic [20:0] cc_rx_word = '0;
  logic cc_tx_valid, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_port_regs dut (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string stat_tag = "R9";

  logic [15:0] qa_tx[$], qa_rx[$], qt_tx[$], qt_rx[$];
  logic a_unf = 0, a_ovr = 0, t_unf = 0, t_ovr = 0;
  logic [15:0] a_txs = '0, t_txs = '0;
  logic [4:0] m_ca = '0;
  logic [1:0] m_cb = '0;
  logic m_pend = 0, m_wait = 0, m_done = 0, m_txv = 0;
  logic [20:0] m_txw = '0, m_rdw = '0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0] = a_unf; s[1] = a_ovr; s[2] = t_unf; s[3] = t_ovr;
    s[4] = qa_tx.size() <= 4; s[5] = qa_rx.size() >= 4;
    s[6] = qt_tx.size() <= 4; s[7] = qt_rx.size() >= 4;
    s[8] = qa_tx.size() != 8; s[9] = qa_rx.size() != 0;
    s[10] = qt_tx.size() != 8; s[11] = qt_rx.size() != 0;
    s[12] = m_done; s[13] = m_cb[0]; s[14] = m_cb[1];
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_status();
    return m_ca[0] && ((|s[3:0]) || (|(s[7:4] & m_ca[4:1])));
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_ca};
      3'd1: return {30'd0, m_cb};
      3'd2: return (qa_rx.size() > 0) ? {16'd0, qa_rx[0]} : 32'd0;
      3'd3: return (qt_rx.size() > 0) ? {16'd0, qt_rx[0]} : 32'd0;
      3'd4: return {11'd0, m_rdw};
      3'd5: return exp_status();
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3: return "R3";
      3'd4: return "R10";
      3'd5: return stat_tag;
      default: return "R1";
    endcase
  endfunction

  task automatic chmodel(ref logic [15:0] tq[$], ref logic [15:0] rq[$],
                         ref logic unf, ref logic ovr, ref logic [15:0] txs,
                         input logic push, input logic [15:0] pd, input logic pop,
                         input logic slot, input logic [15:0] rs,
                         input logic cu, input logic co, input logic en);
    int nt, nr;
    nt = tq.size();
    nr = rq.size();
    if (cu) unf = 0;
    if (co) ovr = 0;
    if (slot && en) begin
      if (nt > 0) txs = tq.pop_front();
      else unf = 1;
    end
    if (push && nt < 8) tq.push_back(pd);
    if (pop && nr > 0) void'(rq.pop_front());
    if (slot && en) begin
      if (nr < 8) rq.push_back(rs);
      else ovr = 1;
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                      input logic [31:0] wd, input logic as, input logic [15:0] ar,
                      input logic ts, input logic [15:0] tr, input logic cf,
                      input logic rf, input logic [20:0] rw);
    logic en, ws;
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
    aud_slot = as; aud_rx_sample = ar; tel_slot = ts; tel_rx_sample = tr;
    cc_tx_frame = cf; cc_rx_frame = rf; cc_rx_word = rw;
    #1;
    if (rd) check(tag_for(a), host_rdata, exp_read(a));
    check("R11", {31'd0, irq}, {31'd0, exp_irq()});
    en = m_ca[0];
    ws = wr && a == 3'd5;
    chmodel(qa_tx, qa_rx, a_unf, a_ovr, a_txs, wr && a == 3'd2, wd[15:0],
            rd && a == 3'd2, as, ar, ws && wd[0], ws && wd[1], en);
    chmodel(qt_tx, qt_rx, t_unf, t_ovr, t_txs, wr && a == 3'd3, wd[15:0],
            rd && a == 3'd3, ts, tr, ws && wd[2], ws && wd[3], en);
    m_txv = 0;
    if (wr && a == 3'd4) begin
      m_txw = wd[20:0]; m_pend = 1; m_wait = 0; m_done = 0;
    end else begin
      if (en && cf && m_pend) begin m_txv = 1; m_pend = 0; m_wait = 1; end
      else if (en && rf && m_wait) begin m_rdw = rw; m_done = 1; m_wait = 0; end
    end
    if (wr && a == 3'd0) m_ca = wd[4:0];
    if (wr && a == 3'd1) m_cb = wd[1:0];
    @(posedge clk);
    @(negedge clk);
    check("R2", {16'd0, aud_tx_sample}, {16'd0, a_txs});
    check("R2", {16'd0, tel_tx_sample}, {16'd0, t_txs});
    check("R10", {31'd0, cc_tx_valid}, {31'd0, m_txv});
    if (m_txv) check("R10", {11'd0, cc_tx_word}, {11'd0, m_txw});
    host_wr = 0; host_rd = 0; aud_slot = 0; tel_slot = 0;
    cc_tx_frame = 0; cc_rx_frame = 0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    step(1, 0, a, d, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rreg(input logic [2:0] a);
    step(0, 1, a, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    stat_tag = "R1";
    check("R1", {16'd0, aud_tx_sample}, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    rreg(3'd5);
    check("R1", host_rdata, 32'h0550);
    rreg(3'd0); rreg(3'd1);
    wreg(3'd0, 32'h1F);
    rreg(3'd0);
    // R4 overfill audio tx, R5/R6 via slots
    stat_tag = "R4";
    for (int i = 0; i < 9; i++) wreg(3'd2, 32'h100 + i);
    rreg(3'd5);
    for (int i = 0; i < 9; i++) step(0, 0, 3'd2, 0, 1, 16'h200 + 16'(i), 0, 0, 0, 0, 0);
    check("R6", {16'd0, aud_tx_sample}, 32'h0107);
    stat_tag = "R5";
    rreg(3'd5);
    check("R5", host_rdata & 32'h3, 32'h3);
    // R7 write-1-to-clear
    stat_tag = "R7";
    wreg(3'd5, 32'h0);
    rreg(3'd5);
    wreg(3'd5, 32'h1);
    rreg(3'd5);
    check("R7", host_rdata & 32'h3, 32'h2);
    wreg(3'd5, 32'h2);
    rreg(3'd5);
    // R3 drain receive past empty
    for (int i = 0; i < 9; i++) rreg(3'd2);
    check("R3", host_rdata, 32'd0);
    // R8 thresholds
    stat_tag = "R8";
    for (int i = 0; i < 4; i++) wreg(3'd2, 32'h300 + i);
    rreg(3'd5);
    wreg(3'd2, 32'h304);
    rreg(3'd5);
    for (int i = 0; i < 3; i++) step(0, 0, 3'd3, 0, 0, 0, 1, 16'h400 + 16'(i), 0, 0, 0);
    rreg(3'd5);
    step(0, 0, 3'd3, 0, 0, 0, 1, 16'h403, 0, 0, 0);
    rreg(3'd5);
    rreg(3'd3);
    rreg(3'd5);
    // R12 disabled strobes
    stat_tag = "R12";
    wreg(3'd0, 32'h0);
    for (int i = 0; i < 3; i++) step(0, 0, 3'd0, 0, 1, 16'hAAAA, 1, 16'hBBBB, 1, 1, 21'h1);
    rreg(3'd5);
    rreg(3'd3);
    wreg(3'd0, 32'h1F);
    // R10 control word round trip
    stat_tag = "R10";
    wreg(3'd4, 32'h1ABCDE);
    rreg(3'd5);
    step(0, 0, 3'd0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 3'd0, 0, 0, 0, 0, 0, 0, 1, 21'h12345);
    rreg(3'd5);
    rreg(3'd4);
    check("R10", host_rdata, 32'h12345);
    // R9 codec-on bits
    stat_tag = "R9";
    wreg(3'd1, 32'h3);
    rreg(3'd5);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] op;
      logic [31:0] d;
      logic as, ts, cf, rf;
      op = 4'($urandom % 16);
      d = $urandom;
      as = ($urandom % 3) == 0;
      ts = ($urandom % 4) == 0;
      cf = ($urandom % 8) == 0;
      rf = ($urandom % 8) == 0;
      case (op)
        0, 1, 2, 3: step(1, 0, 3'd2, d, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        4, 5:       step(1, 0, 3'd3, d, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        6, 7:       step(0, 1, 3'd2, 0, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        8:          step(0, 1, 3'd3, 0, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        9:          step(0, 1, 3'd5, 0, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        10:         step(1, 0, 3'd5, {28'd0, d[3:0]}, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        11:         step(1, 0, 3'd0, {27'd0, d[4:1], (d[7:5] != 0)}, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        12:         step(1, 0, 3'd4, d, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        13:         step(0, 1, 3'd4, 0, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        14:         step(1, 0, 3'd1, d, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
        default:    step(0, 1, 3'd0, 0, as, 16'($urandom), ts, 16'($urandom), cf, rf, 21'($urandom));
      endcase
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule